// File: doc/BRIEF.md
# Idle-Qualified Asynchronous Serial Receiver

This block pulls 8-bit characters off an asynchronous serial line that may already be busy when the receiver comes out of reset. It does not accept the first falling edge it sees. It first hunts for a stretch of unbroken high level whose length is set in bit periods by an input port. The intended setting is 10 bit periods, which the package exports as a constant. Only after that gap does a high-to-low transition count as a start bit. From then on it times every sample from that edge: the start bit is checked again at mid-bit, and each data bit and the stop bit are sampled at their centres.

A good stop bit delivers the byte with a one-cycle strobe. The receiver then stays armed, so back-to-back characters are taken without any further gap. A low stop bit raises a one-cycle framing-error strobe and drops the byte. The receiver then goes back to hunting for idle, so it cannot stay locked onto an edge inside a character. Timing comes from an oversampling tick whose spacing in clock cycles is set by a divisor port. The raw line passes through a two-flop synchronizer before any logic looks at it.

Top module: `uart_idle_rx`

## Requirements
- R1: After reset `armed` is 0 and no strobe is raised. `armed` goes to 1 only after the synchronized line has been high for `idle_bits` × OVS consecutive oversampling ticks. With the default `idle_bits` of 10 and OVS = 16, it is still 0 after 5 bit periods of high and is 1 after 12.
- R2: Any low sample while hunting restarts the idle count from zero.
- R3: Data bits are sampled at mid-bit and shifted in least significant bit first. After a high stop bit, `rx_data` holds the byte and `rx_valid` is high for exactly one clock.
- R4: A low level at the stop-bit sample pulses `frame_err` for one clock, produces no `rx_valid`, and returns the receiver to hunting, so `armed` reads 0.
- R5: After a framing error, no frame is accepted until a full idle gap has been seen again. A frame that follows a full gap is received normally.
- R6: After a valid frame the receiver stays armed, and a frame whose start bit directly follows the previous stop bit is received.
- R7: If the line is high again at the mid-point of the start bit, the edge is dropped as a glitch. No strobe is produced and `armed` returns to 1.
- R8: An oversampling tick occurs every `os_div`+1 clocks, and one bit period is OVS ticks. Frames sent at the matching rate are received for `os_div` values 0, 1 and 2.
- R9: The idle gap follows `idle_bits`. With 3 the receiver is unarmed after 2 bit periods and armed after 4. With 0 it arms on the first high tick.
- R10: `rx_line` reaches the logic through two flops. A falling edge driven on the line leaves `armed` at 1 for two clocks and clears it on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_div | input | DIV_W | Clocks per oversampling tick, minus one |
| idle_bits | input | IDLE_W | Idle gap length in bit periods required before arming |
| rx_line | input | 1 | Raw asynchronous serial input, idles high |
| rx_data | output | DATA_W | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-clock strobe when `rx_data` is updated |
| frame_err | output | 1 | One-clock strobe on a low stop bit |
| armed | output | 1 | High while waiting for a start edge |

## Verification
Bytes with alternating bits, all zeros, all ones and mixed patterns are sent at three divisor settings. These patterns show whether the bit order, the mid-bit timing and the tick spacing are correct. Back-to-back frames test whether the receiver stays armed after a stop bit. A two-clock low pulse tests the mid-start recheck and, from the time `armed` falls, the synchronizer depth. A frame with a low stop bit, followed at once by a frame of zeros, tests whether the receiver really returns to hunting rather than accepting the next edge. Idle runs broken by a low bit, and different gap settings, test the exact point at which the receiver arms.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned IDLE_BITS_DFLT = 10;

  typedef enum logic [2:0] {
    S_HUNT  = 3'd0,
    S_ARMED = 3'd1,
    S_START = 3'd2,
    S_DATA  = 3'd3,
    S_STOP  = 3'd4
  } rx_state_e;

  // Minimum clocks of continuous high before arming may occur.
  function automatic int unsigned min_idle_clocks(int unsigned bits, int unsigned ovs,
                                                  int unsigned div);
    int unsigned t;
    t = bits * ovs;
    return (t == 0) ? 0 : (t - 1) * (div + 1);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= d_in;
      s2 <= s1;
    end
  end

  assign d_out = s2;
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] os_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= os_div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int IDLE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_s,
  input  logic [IDLE_W-1:0] idle_bits,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              ferr_q,
  output logic              armed,
  output logic              hunt_done,
  output logic              start_seen,
  output logic              glitch_seen
);
  localparam int OVS_W = $clog2(OVS);
  localparam int HW    = IDLE_W + OVS_W;
  localparam int HALF  = OVS / 2;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         state;
  logic [OVS_W-1:0]  os_cnt;
  logic [HW-1:0]     hunt_cnt;
  logic [HW-1:0]     target;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              mid_start;
  logic              bit_end;

  assign target      = HW'(idle_bits) * HW'(OVS);
  assign hunt_done   = (state == S_HUNT) && tick && line_s && ((hunt_cnt + HW'(1)) >= target);
  assign start_seen  = (state == S_ARMED) && tick && !line_s;
  assign mid_start   = (state == S_START) && tick && (os_cnt == OVS_W'(HALF - 1));
  assign glitch_seen = mid_start && line_s;
  assign bit_end     = tick && (os_cnt == OVS_W'(OVS - 1));
  assign armed       = (state == S_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_HUNT;
      os_cnt   <= '0;
      hunt_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      case (state)
        S_HUNT: begin
          if (tick) begin
            if (!line_s) hunt_cnt <= '0;
            else if (hunt_done) begin
              hunt_cnt <= '0;
              state    <= S_ARMED;
            end else hunt_cnt <= hunt_cnt + HW'(1);
          end
        end
        S_ARMED: begin
          if (start_seen) begin
            os_cnt <= '0;
            state  <= S_START;
          end
        end
        S_START: begin
          if (mid_start) begin
            os_cnt <= '0;
            if (line_s) state <= S_ARMED;
            else begin
              bit_idx <= '0;
              state   <= S_DATA;
            end
          end else if (tick) os_cnt <= os_cnt + OVS_W'(1);
        end
        S_DATA: begin
          if (bit_end) begin
            os_cnt  <= '0;
            shreg   <= {line_s, shreg[DATA_W-1:1]};
            bit_idx <= bit_idx + BIT_W'(1);
            if (bit_idx == BIT_W'(DATA_W - 1)) state <= S_STOP;
          end else if (tick) os_cnt <= os_cnt + OVS_W'(1);
        end
        S_STOP: begin
          if (bit_end) begin
            os_cnt <= '0;
            if (line_s) begin
              data_q  <= shreg;
              valid_q <= 1'b1;
              state   <= S_ARMED;
            end else begin
              ferr_q   <= 1'b1;
              hunt_cnt <= '0;
              state    <= S_HUNT;
            end
          end else if (tick) os_cnt <= os_cnt + OVS_W'(1);
        end
        default: state <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx #(
  parameter int OVS    = 16,
  parameter int IDLE_W = 8,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  os_div,
  input  logic [IDLE_W-1:0] idle_bits,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              armed
);
  logic line_s;
  logic tick;
  logic hunt_done;
  logic start_seen;
  logic glitch_seen;

  uart_rx_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_line),
    .d_out (line_s)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .os_div (os_div),
    .tick   (tick)
  );

  uart_rx_fsm #(.OVS(OVS), .IDLE_W(IDLE_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .line_s      (line_s),
    .idle_bits   (idle_bits),
    .data_q      (rx_data),
    .valid_q     (rx_valid),
    .ferr_q      (frame_err),
    .armed       (armed),
    .hunt_done   (hunt_done),
    .start_seen  (start_seen),
    .glitch_seen (glitch_seen)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int IDLE_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  os_div,
  input logic [IDLE_W-1:0] idle_bits,
  input logic              rx_line,
  input logic              line_s,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              armed,
  input logic              hunt_done,
  input logic              start_seen,
  input logic              glitch_seen
);
  int unsigned hi_cnt;
  int unsigned need;

  assign need = min_idle_clocks(32'(idle_bits), OVS, 32'(os_div));

  always_ff @(posedge clk) begin
    if (!rst_n || !line_s)      hi_cnt <= 0;
    else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
  end

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_done |-> (hi_cnt >= need)); // R1
  AST_ARM_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(line_s)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R4
  AST_ERR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!armed && !rx_valid)); // R4
  AST_VALID_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> armed); // R6
  AST_GLITCH_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_seen |=> (armed && !rx_valid && !frame_err)); // R7
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |-> !$past(rx_line, 2)); // R10
endmodule

bind uart_idle_rx uart_rx_chk #(.OVS(OVS), .IDLE_W(IDLE_W), .DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .os_div      (os_div),
  .idle_bits   (idle_bits),
  .rx_line     (rx_line),
  .line_s      (line_s),
  .rx_valid    (rx_valid),
  .frame_err   (frame_err),
  .armed       (armed),
  .hunt_done   (hunt_done),
  .start_seen  (start_seen),
  .glitch_seen (glitch_seen)
);

// File: tb/tb_uart_idle_rx.sv
`timescale 1ns/1ps
module tb_uart_idle_rx;
  import uart_rx_pkg::*;

  localparam int OVS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] os_div = '0;
  logic [7:0]  idle_bits = 8'(IDLE_BITS_DFLT);
  logic        rx_line = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, frame_err, armed;

  int n_run = 0, n_fail = 0;
  int n_valid = 0, n_err = 0;
  int bitclk = OVS;
  logic [7:0] last_data = '0, prev_data = '0;

  always #4 clk = ~clk;

  uart_idle_rx dut (
    .clk(clk), .rst_n(rst_n), .os_div(os_div), .idle_bits(idle_bits),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .armed(armed)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      n_valid++;
      prev_data = last_data;
      last_data = rx_data;
    end
    if (frame_err) n_err++;
  end

  // {os_div[1:0], byte}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h55}, {2'd0, 8'hA3}, {2'd0, 8'h00},
    {2'd1, 8'hFF}, {2'd2, 8'h81}, {2'd0, 8'h3C}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    os_div = 16'(d);
    bitclk = OVS * (d + 1);
  endtask

  task automatic idle(input int nbits);
    rx_line = 1'b1;
    clocks(nbits * bitclk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_lvl);
    rx_line = 1'b0;
    clocks(bitclk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      clocks(bitclk);
    end
    rx_line = stop_lvl;
    clocks(bitclk);
    rx_line = 1'b1;
  endtask

  task automatic do_reset(input int idle_set);
    rst_n = 1'b0;
    rx_line = 1'b1;
    idle_bits = 8'(idle_set);
    set_div(0);
    clocks(4);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v0, e0;
    do_reset(IDLE_BITS_DFLT);
    // R1 reset state and arming point
    check(!armed && !rx_valid && !frame_err, "R1 reset", armed, 0);
    idle(5);
    check(!armed, "R1 before gap", armed, 0);
    idle(7);
    check(armed, "R1 after gap", armed, 1);

    // R3 / R8 vector table
    for (int i = 0; i < 6; i++) begin
      set_div(int'(VEC[i][9:8]));
      idle(2);
      v0 = n_valid;
      send_frame(VEC[i][7:0], 1'b1);
      idle(1);
      check(n_valid == v0 + 1, "R3 strobe count", n_valid - v0, 1);
      check(last_data == VEC[i][7:0], (VEC[i][9:8] != 0) ? "R8 divisor data" : "R3 data",
            last_data, VEC[i][7:0]);
    end
    set_div(0);

    // R6 back-to-back
    idle(2);
    v0 = n_valid;
    send_frame(8'h12, 1'b1);
    send_frame(8'hE7, 1'b1);
    idle(1);
    check(n_valid == v0 + 2, "R6 count", n_valid - v0, 2);
    check(prev_data == 8'h12 && last_data == 8'hE7, "R6 data", {prev_data, last_data}, 16'h12E7);

    // R10 / R7 glitch
    v0 = n_valid; e0 = n_err;
    rx_line = 1'b0;
    clocks(2);
    check(armed, "R10 sync hold", armed, 1);
    rx_line = 1'b1;
    clocks(2);
    check(!armed, "R10 edge seen", armed, 0);
    idle(2);
    check(armed && n_valid == v0 && n_err == e0, "R7 glitch", {armed, n_valid - v0, n_err - e0}, 1);

    // R4 / R5 framing error then no relock
    idle(1);
    v0 = n_valid; e0 = n_err;
    send_frame(8'h5A, 1'b0);
    send_frame(8'h00, 1'b1);
    idle(3);
    check(n_err == e0 + 1, "R4 err count", n_err - e0, 1);
    check(!armed, "R4 back to hunt", armed, 0);
    check(n_valid == v0, "R5 no relock", n_valid - v0, 0);
    idle(12);
    check(armed, "R5 rearmed", armed, 1);
    send_frame(8'h6B, 1'b1);
    idle(1);
    check(n_valid == v0 + 1 && last_data == 8'h6B, "R5 accept", last_data, 8'h6B);

    // R2 low restarts count
    do_reset(IDLE_BITS_DFLT);
    idle(8);
    rx_line = 1'b0;
    clocks(bitclk);
    idle(8);
    check(!armed, "R2 restart", armed, 0);
    idle(3);
    check(armed, "R2 armed later", armed, 1);

    // R9 programmable gap
    do_reset(3);
    idle(2);
    check(!armed, "R9 gap3 early", armed, 0);
    idle(2);
    check(armed, "R9 gap3 armed", armed, 1);
    do_reset(0);
    idle(1);
    check(armed, "R9 gap0 armed", armed, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule